// File: doc/BRIEF.md
# Quarter-Rate Quadrature Downmixer

This block turns a real, sampled IF stream into a pair of baseband streams, I and Q, for a receiver whose carrier sits at one quarter of the sample rate. Each accepted input word is 9 bits wide. A control bit selects how it is read: signed two's complement, or offset binary. Once the word is in signed form, the block multiplies it by a fixed rotating weight in each branch. The weights are only +1, 0 and −1, so the mixer has no oscillator and no multiplier.

A shared 2-bit phase counter sets which weight applies. It moves on by one for every accepted sample, so I and Q stay aligned. The two outputs are registered and carry a valid flag that follows the input valid one clock later. A second control bit flips the sign of every Q weight. This lets the spectrum be mirrored without touching the I branch. Both control bits are read together with each sample, so a change applies to the next accepted sample and the phase is not disturbed.

The signed value in the middle of the path is the level a downstream gain detector would see. The following root-raised-cosine filters take the I and Q streams directly.

Top module: `fs4_downmix`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0, `out_i` and `out_q` are 0, and the next accepted sample uses phase 0.
- R2: Control bit 0 selects the input format. With 0, `in_data` is signed two's complement. With 1, it is offset binary, and its signed value is `in_data` with bit 8 inverted (9'h000 means −256, 9'h1FF means +255).
- R3: For accepted samples at phases 0, 1, 2, 3, `out_i` is +x, 0, −x, 0, where x is the signed sample.
- R4: With control bit 1 clear, for phases 0, 1, 2, 3, `out_q` is 0, −x, 0, +x.
- R5: With control bit 1 set, `out_q` is 0, +x, 0, −x for phases 0 to 3. `out_i` is not affected.
- R6: Negation is exact for −255..+255. A sample of −256 in a negating phase yields +255. A +1 weight passes −256 unchanged.
- R7: `out_i`, `out_q` and `out_valid` update one clock after the sample is accepted. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. Without a new sample, `out_i` and `out_q` hold their values.
- R8: The phase advances by one (modulo 4) for each accepted sample only. Idle cycles leave it unchanged.
- R9: A change of either control bit applies to the next accepted sample and does not reset the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 9 | Sampled IF word |
| ctrl | input | 2 | Bit 0: offset-binary select; bit 1: Q sign inversion |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 9 | Signed in-phase baseband sample |
| out_q | output | 9 | Signed quadrature baseband sample |

## Verification
The bench builds the block with its default width of 9 bits. At this width both extreme codes, −256 and +255, can be driven in each format. That exercises the negation saturation and the exact symmetric range in both the I and Q branches. Idle gaps and per-sample changes of the control bits show that the phase depends only on accepted samples.

// File: rtl/fs4_pkg.sv
package fs4_pkg;
  localparam int unsigned PH_W = 2;

  typedef struct packed {
    logic q_inv;       // bit 1
    logic fmt_offset;  // bit 0
  } ctrl_t;

  typedef enum logic [PH_W-1:0] {
    PH_0 = 2'd0,
    PH_1 = 2'd1,
    PH_2 = 2'd2,
    PH_3 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    WT_ZERO = 2'd0,
    WT_POS  = 2'd1,
    WT_NEG  = 2'd2
  } weight_e;
endpackage

// File: rtl/fs4_rst_sync.sv
module fs4_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fs4_fmt_conv.sv
module fs4_fmt_conv #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0]        raw,
  input  logic                fmt_offset,
  output logic signed [W-1:0] sample
);
  // Offset binary differs from two's complement only in the sign bit.
  always_comb begin
    sample = raw;
    if (fmt_offset) sample[W-1] = ~raw[W-1];
  end
endmodule

// File: rtl/fs4_phase_ctr.sv
module fs4_phase_ctr
  import fs4_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  output phase_e phase
);
  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (adv) phase_d = phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/fs4_lane.sv
module fs4_lane
  import fs4_pkg::*;
#(
  parameter int unsigned W      = 9,
  parameter bit          Q_LANE = 1'b0
) (
  input  phase_e              phase,
  input  logic                flip,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] mixed
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  weight_e             wt;
  logic signed [W-1:0] negated;

  generate
    if (Q_LANE) begin : g_q
      always_comb begin
        unique case (phase)
          PH_1:    wt = flip ? WT_POS : WT_NEG;
          PH_3:    wt = flip ? WT_NEG : WT_POS;
          default: wt = WT_ZERO;
        endcase
      end
    end else begin : g_i
      logic unused_flip;
      assign unused_flip = flip;
      always_comb begin
        unique case (phase)
          PH_0:    wt = WT_POS;
          PH_2:    wt = WT_NEG;
          default: wt = WT_ZERO;
        endcase
      end
    end
  endgenerate

  // Two's complement negate; the one code without a positive twin saturates.
  always_comb begin
    if (sample == MOST_NEG) negated = MOST_POS;
    else                    negated = ~sample + ONE;
  end

  always_comb begin
    unique case (wt)
      WT_POS:  mixed = sample;
      WT_NEG:  mixed = negated;
      default: mixed = '0;
    endcase
  end
endmodule

// File: rtl/fs4_downmix.sv
module fs4_downmix
  import fs4_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [W-1:0]        in_data,
  input  logic [1:0]          ctrl,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  ctrl_t               cfg;
  logic                rst_n_int;
  logic                accept;
  phase_e              phase;
  logic signed [W-1:0] sample;
  logic signed [W-1:0] mix_i;
  logic signed [W-1:0] mix_q;

  logic                vld_q, vld_d;
  logic signed [W-1:0] i_q, i_d;
  logic signed [W-1:0] q_q, q_d;

  assign cfg = ctrl_t'(ctrl);

  fs4_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign accept = in_valid & rst_n_int;

  fs4_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n_int),
    .adv   (accept),
    .phase (phase)
  );

  fs4_fmt_conv #(.W(W)) u_conv (
    .raw        (in_data),
    .fmt_offset (cfg.fmt_offset),
    .sample     (sample)
  );

  fs4_lane #(.W(W), .Q_LANE(1'b0)) u_lane_i (
    .phase  (phase),
    .flip   (1'b0),
    .sample (sample),
    .mixed  (mix_i)
  );

  fs4_lane #(.W(W), .Q_LANE(1'b1)) u_lane_q (
    .phase  (phase),
    .flip   (cfg.q_inv),
    .sample (sample),
    .mixed  (mix_q)
  );

  always_comb begin
    vld_d = accept;
    i_d   = i_q;
    q_d   = q_q;
    if (accept) begin
      i_d = mix_i;
      q_d = mix_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      i_q   <= '0;
      q_q   <= '0;
    end else begin
      vld_q <= vld_d;
      i_q   <= i_d;
      q_q   <= q_d;
    end
  end

  assign out_valid = vld_q;
  assign out_i     = i_q;
  assign out_q     = q_q;
endmodule

// File: rtl/fs4_downmix_chk.sv
module fs4_downmix_chk #(
  parameter int unsigned W = 9
) (
  input logic                clk,
  input logic                rst_n_int,
  input logic                in_valid,
  input logic [W-1:0]        in_data,
  input logic [1:0]          ctrl,
  input logic [1:0]          phase,
  input logic                out_valid,
  input logic signed [W-1:0] out_i,
  input logic signed [W-1:0] out_q
);
  localparam logic [W-1:0] MIN_TC  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MIN_OFS = '0;
  localparam logic [W-1:0] MAX_S   = {1'b0, {(W-1){1'b1}}};

  // R7: valid follows input strobe by one clock
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_valid |=> out_valid);
  a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));

  // R3: odd phases give zero on I
  a_r3_i_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && phase[0]) |=> (out_i == '0));

  // R4 / R5: even phases give zero on Q
  a_r4_q_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && !phase[0]) |=> (out_q == '0));

  // R6: most negative input negated on I at phase 2 saturates
  a_r6_sat_i: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && phase == 2'd2 &&
     in_data == (ctrl[0] ? MIN_OFS : MIN_TC)) |=> (out_i == MAX_S));

  // R8: phase moves only on accepted samples
  a_r8_adv: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_valid |=> (phase == $past(phase) + 2'd1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> $stable(phase));
endmodule

bind fs4_downmix fs4_downmix_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .ctrl      (ctrl),
  .phase     (phase),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/fs4_downmix_bench.sv
module fs4_downmix_bench;
  localparam int W = 9;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [W-1:0]       in_data = '0;
  logic [1:0]         ctrl = 2'b00;
  logic               out_valid;
  logic signed [W-1:0] out_i;
  logic signed [W-1:0] out_q;

  typedef struct {
    logic [W-1:0] ei;
    logic [W-1:0] eq;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           checks = 0;
  int           errors = 0;
  int           ph = 0;
  logic [W-1:0] last_i = '0;
  logic [W-1:0] last_q = '0;
  bit           done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fs4_downmix #(.W(W)) u_fs4_downmix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .ctrl      (ctrl),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  function automatic int to_int(logic [W-1:0] raw, bit offs);
    int v;
    v = offs ? int'(raw) - 256 : int'($signed(raw));
    return v;
  endfunction

  function automatic int neg_sat(int x);
    return (x == -256) ? 255 : -x;
  endfunction

  task automatic check(string tag, bit ok, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(logic [W-1:0] raw, logic [1:0] c, string tag);
    exp_t e;
    int   x, ei, eq;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = raw;
    ctrl     = c;
    x  = to_int(raw, c[0]);
    ei = 0;
    eq = 0;
    case (ph)
      0: ei = x;
      1: eq = c[1] ? x : neg_sat(x);
      2: ei = neg_sat(x);
      default: eq = c[1] ? neg_sat(x) : x;
    endcase
    e.ei  = W'(ei);
    e.eq  = W'(eq);
    e.tag = tag;
    sb.push_back(e);
    ph = (ph + 1) % 4;
  endtask

  task automatic idle(int n, logic [1:0] c);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 9'h0AA;
      ctrl     = c;
    end
    @(negedge clk);
    // R7: no strobe and held data; R8 checked when sampling resumes
    check("R7 idle valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R7 hold", (out_i == last_i) && (out_q == last_q),
          int'(out_i), int'($signed(last_i)));
  endtask

  // Monitor: pops the scoreboard on every output strobe
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R7 unexpected valid", 1'b0, 1, 0);
        end else begin
          e = sb.pop_front();
          check({e.tag, " I"}, out_i == e.ei, int'(out_i), int'($signed(e.ei)));
          check({e.tag, " Q"}, out_q == e.eq, int'(out_q), int'($signed(e.eq)));
          last_i = out_i;
          last_q = out_q;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R1 reset I/Q", (out_i == '0) && (out_q == '0), int'(out_i), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-release", !out_valid && out_i == '0, int'(out_valid), 0);

    // R3 / R4 / R7: constant then mixed two's complement
    drive(9'd100, 2'b00, "R3 R4 R7 const");
    drive(9'd100, 2'b00, "R3 R4 R7 const");
    drive(9'd100, 2'b00, "R3 R4 R7 const");
    drive(9'd100, 2'b00, "R3 R4 R7 const");
    drive(9'd37,        2'b00, "R3 R4 mixed");
    drive(W'(-5),       2'b00, "R3 R4 mixed");
    drive(W'(-77),      2'b00, "R3 R4 mixed");
    drive(9'd200,       2'b00, "R3 R4 mixed");

    // R2: offset binary (R6 on Q at phase 1)
    drive(9'h1FF, 2'b01, "R2 offset max");
    drive(9'h000, 2'b01, "R2 R6 offset min");
    drive(9'h180, 2'b01, "R2 offset 128");
    drive(9'h0C0, 2'b01, "R2 offset -64");

    // R5: Q inversion
    drive(9'd50, 2'b10, "R5 inv");
    drive(9'd50, 2'b10, "R5 inv");
    drive(9'd50, 2'b10, "R5 inv");
    drive(9'd50, 2'b10, "R5 inv");

    // R7 / R8: gaps do not move phase
    drive(9'd11, 2'b00, "R8 before gap");
    idle(3, 2'b11);
    drive(9'd12, 2'b00, "R8 after gap");
    idle(1, 2'b00);
    drive(9'd13, 2'b00, "R8 after gap");
    drive(9'd14, 2'b00, "R8 after gap");

    // R6: saturation and exact extremes
    drive(9'h100, 2'b00, "R6 pass -256");
    drive(9'd1,   2'b00, "R6 filler");
    drive(9'h100, 2'b00, "R6 sat I");
    drive(9'hFF,  2'b00, "R6 filler");
    drive(9'h0FF, 2'b00, "R6 filler");
    drive(9'h100, 2'b00, "R6 sat Q");
    drive(9'h0FF, 2'b00, "R6 exact -255");
    drive(9'h100, 2'b10, "R6 R5 inv -256");

    // R9: control changes per sample, phase continues
    drive(9'd20,  2'b00, "R9 ctrl change");
    drive(9'h0F0, 2'b11, "R9 ctrl change");
    drive(9'd30,  2'b01, "R9 ctrl change");
    drive(9'd40,  2'b10, "R9 ctrl change");
    drive(9'd60,  2'b01, "R9 ctrl change");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 all results seen", sb.size() == 0, sb.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule